// File: doc/BRIEF.md
# Two-Level Microprogram Sequencer

This block turns a stream of opcodes into a stream of microwords. An opcode taken on a valid/ready handshake selects an entry in a decode store. That entry supplies the microword for the instruction's first clock. It also carries a flag saying whether the instruction runs longer and a pointer into a separate continuation store. Each continuation word holds a microword, a link to the next word and a last-word flag. The sequencer follows the links one word per clock until the last word is issued. Then it takes opcodes again.

The upper `N_CUST` opcodes form a loadable custom region. Each execution context has its own copy of that region, and `ctx_sel` picks the copy used for each lookup. The lower opcodes share one standard table. A host loads both stores through plain write ports. A custom instruction's body can therefore sit at any continuation address, and only its decode entry has to change to move it. While one context runs, the host can stage the decode entries of another.

The opcode input is valid/ready. `op_ready` is low while a multi-cycle instruction is running. An opcode offered in that time stays pending, and the source must hold it stable. The microword output is valid-only and has no back-pressure: a consumer must accept one word on every clock in which `uw_valid` is high. Standard decode entries and continuation words hold no defined value until the host writes them.

Top module: `mcseq_top`

## Requirements
- R1: After reset, `op_ready` is 1 and `uw_valid` and `illegal` are 0. Every custom decode entry in every context bank is unloaded, so any custom opcode raises `illegal` until it is written.
- R2: When `op_valid` and `op_ready` are both high at a rising edge, the selected entry's microword appears on `uw_data` with `uw_valid` high in the following cycle. If the entry's multi-cycle flag is clear, `op_ready` stays high and a new opcode can be accepted at the very next edge.
- R3: When an accepted legal entry has its multi-cycle flag set, `op_ready` is low from the cycle after acceptance. On each following clock, one continuation word is issued, starting at the entry's pointer and then following each word's link field. This goes on up to and including the word whose last flag is set. `op_ready` is high again in the cycle after that word is issued, so the microword stream has no gap.
- R4: `uw_valid` is low after any edge at which nothing was accepted and no continuation step ran. An opcode offered while `op_ready` is low is not consumed; it is accepted only at the first edge where `op_ready` is high.
- R5: Opcodes at or above 2^OP_W − N_CUST (56 to 63 by default) read the custom bank chosen by `ctx_sel`, sampled at the acceptance edge. Opcodes below that boundary read the shared standard table whatever `ctx_sel` is.
- R6: A custom opcode whose entry has its loaded bit clear produces a one-cycle `illegal` pulse alongside a `uw_valid` word equal to `NOP_UW` (0 by default). It starts no continuation, even if its multi-cycle flag is set, and `op_ready` stays high.
- R7: Writes through either host port affect only lookups at later edges; a lookup in the same edge as a write sees the old content. Writing the custom bank that `ctx_sel` does not select, while an instruction is in flight, leaves that instruction's microwords unchanged.
- R8: Rewriting only the pointer field of a decode entry moves its instruction to a body stored at the new continuation address. The following issue of that opcode produces the body found at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Sequencer can take an opcode at this edge |
| op_data | input | OP_W | Opcode |
| ctx_sel | input | CX_W | Context bank used for custom opcodes |
| uw_valid | output | 1 | A microword is issued this cycle |
| uw_data | output | UW_W | Issued microword |
| illegal | output | 1 | One-cycle pulse: unloaded custom opcode |
| hd_we | input | 1 | Decode store write strobe |
| hd_ctx | input | CX_W | Bank written for custom opcodes (ignored for standard ones) |
| hd_op | input | OP_W | Opcode whose entry is written |
| hd_valid | input | 1 | Loaded bit for a custom entry |
| hd_multi | input | 1 | Multi-cycle flag |
| hd_cptr | input | CA_W | Continuation pointer |
| hd_uword | input | UW_W | First-clock microword |
| hc_we | input | 1 | Continuation store write strobe |
| hc_addr | input | CA_W | Continuation address written |
| hc_last | input | 1 | Last-word flag |
| hc_link | input | CA_W | Address of the next word |
| hc_uword | input | UW_W | Microword |

## Verification
The bench attacks the boundary between the last continuation word and the next opcode. A design that raised `op_ready` a cycle late would leave a gap in the stream, and one that raised it early would overlap two instructions. An opcode is held on the input during a run; a sequencer that consumed it anyway would issue it twice or drop words. Decode-store writes are made in the same edge as a lookup and into the idle bank mid-run, to catch logic that reads the new value too soon or that decodes the bank from the writer instead of from `ctx_sel`. Unloaded custom entries with the multi-cycle flag set expose a design that starts a continuation for an illegal opcode.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/mcseq_decode_store.sv
module mcseq_decode_store #(
  parameter int OP_W   = 6,
  parameter int N_CUST = 8,
  parameter int N_CTX  = 2,
  parameter int UW_W   = 16,
  parameter int CA_W   = 6,
  localparam int CX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] rd_op,
  input  logic [CX_W-1:0] rd_ctx,
  output logic [UW_W-1:0] rd_uword,
  output logic [CA_W-1:0] rd_cptr,
  output logic            rd_multi,
  output logic            rd_legal,
  input  logic            wr_en,
  input  logic [CX_W-1:0] wr_ctx,
  input  logic [OP_W-1:0] wr_op,
  input  logic            wr_valid,
  input  logic            wr_multi,
  input  logic [CA_W-1:0] wr_cptr,
  input  logic [UW_W-1:0] wr_uword
);
  localparam int N_OPS = 1 << OP_W;
  localparam int N_STD = N_OPS - N_CUST;
  localparam int CI_W  = (N_CUST > 1) ? $clog2(N_CUST) : 1;

  logic [UW_W-1:0] std_uw [N_STD];
  logic [CA_W-1:0] std_cp [N_STD];
  logic            std_mc [N_STD];

  logic            wr_cust, rd_cust;
  logic [OP_W-1:0] wr_off, rd_off;
  logic [CI_W-1:0] wr_idx, rd_idx;

  assign wr_cust = (wr_op >= OP_W'(N_STD));
  assign rd_cust = (rd_op >= OP_W'(N_STD));
  assign wr_off  = wr_op - OP_W'(N_STD);
  assign rd_off  = rd_op - OP_W'(N_STD);
  assign wr_idx  = wr_off[CI_W-1:0];
  assign rd_idx  = rd_off[CI_W-1:0];

  // shared standard table: plain memory, loaded by the host
  always_ff @(posedge clk) begin
    if (wr_en && !wr_cust) begin
      std_uw[wr_op] <= wr_uword;
      std_cp[wr_op] <= wr_cptr;
      std_mc[wr_op] <= wr_multi;
    end
  end

  // per-context custom banks; each bank presents its own read value
  logic [UW_W-1:0] bk_uw [N_CTX];
  logic [CA_W-1:0] bk_cp [N_CTX];
  logic            bk_mc [N_CTX];
  logic            bk_vl [N_CTX];

  for (genvar b = 0; b < N_CTX; b++) begin : g_bank
    logic [UW_W-1:0] uw_q [N_CUST];
    logic [CA_W-1:0] cp_q [N_CUST];
    logic            mc_q [N_CUST];
    logic            vl_q [N_CUST];
    logic            hit;

    assign hit = wr_en && wr_cust && (wr_ctx == CX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < N_CUST; i++) vl_q[i] <= 1'b0;
      end else if (hit) begin
        vl_q[wr_idx] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (hit) begin
        uw_q[wr_idx] <= wr_uword;
        cp_q[wr_idx] <= wr_cptr;
        mc_q[wr_idx] <= wr_multi;
      end
    end

    assign bk_uw[b] = uw_q[rd_idx];
    assign bk_cp[b] = cp_q[rd_idx];
    assign bk_mc[b] = mc_q[rd_idx];
    assign bk_vl[b] = vl_q[rd_idx];
  end

  always_comb begin
    if (rd_cust) begin
      rd_uword = bk_uw[rd_ctx];
      rd_cptr  = bk_cp[rd_ctx];
      rd_multi = bk_mc[rd_ctx];
      rd_legal = bk_vl[rd_ctx];
    end else begin
      rd_uword = std_uw[rd_op];
      rd_cptr  = std_cp[rd_op];
      rd_multi = std_mc[rd_op];
      rd_legal = 1'b1;
    end
  end
endmodule

// File: rtl/mcseq_cont_store.sv
module mcseq_cont_store #(
  parameter int UW_W = 16,
  parameter int CA_W = 6
) (
  input  logic            clk,
  input  logic [CA_W-1:0] rd_addr,
  output logic [UW_W-1:0] rd_uword,
  output logic [CA_W-1:0] rd_link,
  output logic            rd_last,
  input  logic            wr_en,
  input  logic [CA_W-1:0] wr_addr,
  input  logic [UW_W-1:0] wr_uword,
  input  logic [CA_W-1:0] wr_link,
  input  logic            wr_last
);
  localparam int N_WORDS = 1 << CA_W;

  logic [UW_W-1:0] uw_m   [N_WORDS];
  logic [CA_W-1:0] link_m [N_WORDS];
  logic            last_m [N_WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      uw_m[wr_addr]   <= wr_uword;
      link_m[wr_addr] <= wr_link;
      last_m[wr_addr] <= wr_last;
    end
  end

  assign rd_uword = uw_m[rd_addr];
  assign rd_link  = link_m[rd_addr];
  assign rd_last  = last_m[rd_addr];
endmodule

// File: rtl/mcseq_ctrl.sv
module mcseq_ctrl
  import mcseq_pkg::*;
#(
  parameter int              UW_W   = 16,
  parameter int              CA_W   = 6,
  parameter logic [UW_W-1:0] NOP_UW = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [UW_W-1:0] dq_uword,
  input  logic [CA_W-1:0] dq_cptr,
  input  logic            dq_multi,
  input  logic            dq_legal,
  output logic [CA_W-1:0] cs_addr,
  input  logic [UW_W-1:0] cs_uword,
  input  logic [CA_W-1:0] cs_link,
  input  logic            cs_last,
  output logic            uw_valid,
  output logic [UW_W-1:0] uw_data,
  output logic            illegal
);
  seq_state_t      st_q;
  logic [CA_W-1:0] ptr_q;

  assign op_ready = (st_q == ST_IDLE);
  assign cs_addr  = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ptr_q    <= '0;
      uw_valid <= 1'b0;
      uw_data  <= NOP_UW;
      illegal  <= 1'b0;
    end else begin
      uw_valid <= 1'b0;
      illegal  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (op_valid) begin
            uw_valid <= 1'b1;
            if (dq_legal) begin
              uw_data <= dq_uword;
              if (dq_multi) begin
                st_q  <= ST_RUN;
                ptr_q <= dq_cptr;
              end
            end else begin
              uw_data <= NOP_UW;
              illegal <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          uw_valid <= 1'b1;
          uw_data  <= cs_uword;
          if (cs_last) st_q  <= ST_IDLE;
          else         ptr_q <= cs_link;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcseq_top.sv
module mcseq_top #(
  parameter int              OP_W   = 6,
  parameter int              N_CUST = 8,
  parameter int              N_CTX  = 2,
  parameter int              UW_W   = 16,
  parameter int              CA_W   = 6,
  parameter logic [UW_W-1:0] NOP_UW = '0,
  localparam int             CX_W   = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [OP_W-1:0] op_data,
  input  logic [CX_W-1:0] ctx_sel,
  output logic            uw_valid,
  output logic [UW_W-1:0] uw_data,
  output logic            illegal,
  input  logic            hd_we,
  input  logic [CX_W-1:0] hd_ctx,
  input  logic [OP_W-1:0] hd_op,
  input  logic            hd_valid,
  input  logic            hd_multi,
  input  logic [CA_W-1:0] hd_cptr,
  input  logic [UW_W-1:0] hd_uword,
  input  logic            hc_we,
  input  logic [CA_W-1:0] hc_addr,
  input  logic            hc_last,
  input  logic [CA_W-1:0] hc_link,
  input  logic [UW_W-1:0] hc_uword
);
  logic [UW_W-1:0] dq_uword;
  logic [CA_W-1:0] dq_cptr;
  logic            dq_multi;
  logic            dq_legal;
  logic [CA_W-1:0] cs_addr;
  logic [UW_W-1:0] cs_uword;
  logic [CA_W-1:0] cs_link;
  logic            cs_last;

  mcseq_decode_store #(
    .OP_W(OP_W), .N_CUST(N_CUST), .N_CTX(N_CTX), .UW_W(UW_W), .CA_W(CA_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .rd_op(op_data), .rd_ctx(ctx_sel),
    .rd_uword(dq_uword), .rd_cptr(dq_cptr), .rd_multi(dq_multi), .rd_legal(dq_legal),
    .wr_en(hd_we), .wr_ctx(hd_ctx), .wr_op(hd_op), .wr_valid(hd_valid),
    .wr_multi(hd_multi), .wr_cptr(hd_cptr), .wr_uword(hd_uword)
  );

  mcseq_cont_store #(.UW_W(UW_W), .CA_W(CA_W)) u_cont (
    .clk(clk),
    .rd_addr(cs_addr), .rd_uword(cs_uword), .rd_link(cs_link), .rd_last(cs_last),
    .wr_en(hc_we), .wr_addr(hc_addr), .wr_uword(hc_uword),
    .wr_link(hc_link), .wr_last(hc_last)
  );

  mcseq_ctrl #(.UW_W(UW_W), .CA_W(CA_W), .NOP_UW(NOP_UW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready),
    .dq_uword(dq_uword), .dq_cptr(dq_cptr), .dq_multi(dq_multi), .dq_legal(dq_legal),
    .cs_addr(cs_addr), .cs_uword(cs_uword), .cs_link(cs_link), .cs_last(cs_last),
    .uw_valid(uw_valid), .uw_data(uw_data), .illegal(illegal)
  );
endmodule

// File: rtl/mcseq_chk.sv
module mcseq_chk #(
  parameter int              UW_W   = 16,
  parameter logic [UW_W-1:0] NOP_UW = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic            op_ready,
  input logic            uw_valid,
  input logic [UW_W-1:0] uw_data,
  input logic            illegal,
  input logic            dq_multi,
  input logic            dq_legal
);
  // R2: an accepted opcode issues a microword on the next cycle
  p_accept_issues_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> uw_valid);

  // R3: a legal multi-cycle entry drops ready on the next cycle
  p_multi_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && dq_legal && dq_multi) |=> !op_ready);

  // R3: while busy, the next cycle always carries a continuation word
  p_run_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !op_ready |=> uw_valid);

  // R4: no word without an acceptance or a continuation step
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ready && !op_valid) |=> !uw_valid);

  // R6: an illegal pulse carries the no-op word
  p_illegal_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (uw_valid && uw_data == NOP_UW));

  // R6: an illegal opcode starts no continuation
  p_illegal_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> op_ready);

  // R6: an unloaded entry is flagged on the following cycle
  p_unloaded_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !dq_legal) |=> illegal);
endmodule

bind mcseq_top mcseq_chk #(.UW_W(UW_W), .NOP_UW(NOP_UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .uw_valid(uw_valid), .uw_data(uw_data), .illegal(illegal),
  .dq_multi(dq_multi), .dq_legal(dq_legal)
);

// File: tb/mcseq_tb.sv
module mcseq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OP_W   = 6;
  localparam int N_CUST = 8;
  localparam int N_CTX  = 2;
  localparam int UW_W   = 16;
  localparam int CA_W   = 6;
  localparam int N_OPS  = 1 << OP_W;
  localparam int N_STD  = N_OPS - N_CUST;
  localparam int N_CW   = 1 << CA_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic            op_ready;
  logic [OP_W-1:0] op_data = '0;
  logic            ctx_sel = 1'b0;
  logic            uw_valid;
  logic [UW_W-1:0] uw_data;
  logic            illegal;
  logic            hd_we = 1'b0;
  logic            hd_ctx = 1'b0;
  logic [OP_W-1:0] hd_op = '0;
  logic            hd_valid = 1'b0;
  logic            hd_multi = 1'b0;
  logic [CA_W-1:0] hd_cptr = '0;
  logic [UW_W-1:0] hd_uword = '0;
  logic            hc_we = 1'b0;
  logic [CA_W-1:0] hc_addr = '0;
  logic            hc_last = 1'b0;
  logic [CA_W-1:0] hc_link = '0;
  logic [UW_W-1:0] hc_uword = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcseq_top #(.OP_W(OP_W), .N_CUST(N_CUST), .N_CTX(N_CTX), .UW_W(UW_W), .CA_W(CA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_data(op_data), .ctx_sel(ctx_sel), .uw_valid(uw_valid), .uw_data(uw_data),
    .illegal(illegal), .hd_we(hd_we), .hd_ctx(hd_ctx), .hd_op(hd_op),
    .hd_valid(hd_valid), .hd_multi(hd_multi), .hd_cptr(hd_cptr), .hd_uword(hd_uword),
    .hc_we(hc_we), .hc_addr(hc_addr), .hc_last(hc_last), .hc_link(hc_link),
    .hc_uword(hc_uword)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "";

  // reference tables kept from the requirements
  logic [UW_W-1:0] m_suw [N_OPS];
  logic [CA_W-1:0] m_scp [N_OPS];
  logic            m_smc [N_OPS];
  logic [UW_W-1:0] m_buw [N_CTX][N_OPS];
  logic [CA_W-1:0] m_bcp [N_CTX][N_OPS];
  logic            m_bmc [N_CTX][N_OPS];
  logic            m_bvl [N_CTX][N_OPS];
  logic [UW_W-1:0] m_cuw [N_CW];
  logic [CA_W-1:0] m_cln [N_CW];
  logic            m_cla [N_CW];
  bit              m_run = 1'b0;
  logic [CA_W-1:0] m_ptr = '0;
  bit              last_acc;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string pick(input string dflt);
    return (cur_tag != "") ? cur_tag : dflt;
  endfunction

  // one clock: predict, apply model writes, advance, check at the falling edge
  task automatic tick();
    bit e_v, e_ill, lg, mc;
    logic [UW_W-1:0] e_uw, uw;
    logic [CA_W-1:0] cp;
    string src;
    e_v = 0; e_ill = 0; e_uw = '0; src = "R4"; last_acc = 0;
    if (m_run) begin
      e_v = 1; e_uw = m_cuw[m_ptr]; src = "R3";
      if (m_cla[m_ptr]) m_run = 0; else m_ptr = m_cln[m_ptr];
    end else if (op_valid) begin
      e_v = 1; last_acc = 1;
      if (int'(op_data) >= N_STD) begin
        lg = m_bvl[ctx_sel][op_data]; uw = m_buw[ctx_sel][op_data];
        mc = m_bmc[ctx_sel][op_data]; cp = m_bcp[ctx_sel][op_data]; src = "R5";
      end else begin
        lg = 1; uw = m_suw[op_data]; mc = m_smc[op_data]; cp = m_scp[op_data]; src = "R2";
      end
      if (!lg) begin e_uw = '0; e_ill = 1; src = "R6"; end
      else begin
        e_uw = uw;
        if (mc) begin m_run = 1; m_ptr = cp; end
      end
    end
    if (hd_we) begin
      if (int'(hd_op) >= N_STD) begin
        m_buw[hd_ctx][hd_op] = hd_uword; m_bcp[hd_ctx][hd_op] = hd_cptr;
        m_bmc[hd_ctx][hd_op] = hd_multi; m_bvl[hd_ctx][hd_op] = hd_valid;
      end else begin
        m_suw[hd_op] = hd_uword; m_scp[hd_op] = hd_cptr; m_smc[hd_op] = hd_multi;
      end
    end
    if (hc_we) begin
      m_cuw[hc_addr] = hc_uword; m_cln[hc_addr] = hc_link; m_cla[hc_addr] = hc_last;
    end
    @(posedge clk);
    @(negedge clk);
    hd_we = 0; hc_we = 0;
    chk(pick(src), "uw_valid", 32'(uw_valid), 32'(e_v));
    chk(pick(e_ill ? "R6" : src), "illegal", 32'(illegal), 32'(e_ill));
    chk(pick("R3"), "op_ready", 32'(op_ready), 32'(!m_run));
    if (e_v) chk(pick(src), "uw_data", 32'(uw_data), 32'(e_uw));
  endtask

  task automatic send(input logic [OP_W-1:0] op, input logic ctx);
    op_valid = 1; op_data = op; ctx_sel = ctx;
    do tick(); while (!last_acc);
    op_valid = 0;
  endtask

  task automatic wdec(input logic ctx, input logic [OP_W-1:0] op, input logic vl,
                      input logic mc, input logic [CA_W-1:0] cp, input logic [UW_W-1:0] uw);
    hd_we = 1; hd_ctx = ctx; hd_op = op; hd_valid = vl; hd_multi = mc; hd_cptr = cp; hd_uword = uw;
    tick();
  endtask

  task automatic wcont(input logic [CA_W-1:0] a, input logic la,
                       input logic [CA_W-1:0] ln, input logic [UW_W-1:0] uw);
    hc_we = 1; hc_addr = a; hc_last = la; hc_link = ln; hc_uword = uw;
    tick();
  endtask

  task automatic drain();
    while (m_run) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC0_0D17));
    for (int b = 0; b < N_CTX; b++)
      for (int i = 0; i < N_OPS; i++) m_bvl[b][i] = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "op_ready", 32'(op_ready), 32'd1);
    chk("R1", "uw_valid", 32'(uw_valid), 32'd0);
    chk("R1", "illegal", 32'(illegal), 32'd0);

    // R1: every custom entry unloaded in both banks
    cur_tag = "R1";
    for (int b = 0; b < N_CTX; b++)
      for (int o = N_STD; o < N_OPS; o++) send(OP_W'(o), b[0]);
    tick();

    // R2: single-cycle standard instructions back to back
    cur_tag = "R2";
    wdec(0, 6'd3, 0, 0, 6'd0, 16'h1111);
    wdec(0, 6'd4, 0, 0, 6'd0, 16'h2222);
    op_valid = 1; op_data = 6'd3; tick();
    op_data = 6'd4; tick();
    op_data = 6'd3; tick();
    op_valid = 0; tick();

    // R3: three-word body linked out of order
    cur_tag = "R3";
    wcont(6'd10, 0, 6'd20, 16'h00A0);
    wcont(6'd20, 0, 6'd33, 16'h00B0);
    wcont(6'd33, 1, 6'd0,  16'h00C0);
    wdec(0, 6'd5, 0, 1, 6'd10, 16'h5000);
    send(6'd5, 0);
    // R4: next opcode offered while busy must wait
    cur_tag = "R4";
    op_valid = 1; op_data = 6'd3;
    tick(); tick(); tick(); tick();
    op_valid = 0; tick();

    // R5: same custom opcode in two banks, standard opcode ignores ctx
    cur_tag = "R5";
    wdec(0, 6'd57, 1, 0, 6'd0, 16'h0057);
    wdec(1, 6'd57, 1, 0, 6'd0, 16'h1057);
    send(6'd57, 0);
    send(6'd57, 1);
    send(6'd3, 1);
    tick();

    // R6: unloaded entry with multi flag set
    cur_tag = "R6";
    wdec(0, 6'd58, 0, 1, 6'd10, 16'hDEAD);
    send(6'd58, 0);
    tick();

    // R7: same-edge write reads old value; write idle bank mid-run
    cur_tag = "R7";
    wcont(6'd40, 0, 6'd41, 16'h4040);
    wcont(6'd41, 1, 6'd0,  16'h4141);
    wdec(1, 6'd59, 1, 1, 6'd40, 16'h5959);
    op_valid = 1; op_data = 6'd57; ctx_sel = 1;
    hd_we = 1; hd_ctx = 1; hd_op = 6'd57; hd_valid = 1; hd_multi = 0; hd_cptr = '0; hd_uword = 16'hBEEF;
    tick();
    op_valid = 0; tick();
    send(6'd59, 1);
    wdec(0, 6'd59, 1, 0, 6'd1, 16'h7777);
    wdec(0, 6'd59, 0, 1, 6'd2, 16'h8888);
    drain(); tick();

    // R8: relocate the body of opcode 59 to a new address
    cur_tag = "R8";
    wcont(6'd50, 0, 6'd51, 16'h5050);
    wcont(6'd51, 0, 6'd52, 16'h5151);
    wcont(6'd52, 1, 6'd0,  16'h5252);
    wdec(1, 6'd59, 1, 1, 6'd50, 16'h5959);
    send(6'd59, 1);
    drain(); tick();

    // random phase: chains always terminate (link above address or last)
    cur_tag = "";
    for (int a = 0; a < N_CW; a++) begin
      logic la;
      la = (a == N_CW - 1) || ($urandom % 4 == 0);
      wcont(CA_W'(a), la, la ? CA_W'(0) : CA_W'(a + 1 + int'($urandom % (N_CW - 1 - a))), 16'($urandom));
    end
    for (int o = 0; o < N_OPS; o++)
      for (int b = 0; b < N_CTX; b++)
        if (o >= N_STD || b == 0)
          wdec(b[0], OP_W'(o), ($urandom % 4) != 0, $urandom % 2, CA_W'($urandom), 16'($urandom));
    for (int n = 0; n < 4000; n++) begin
      if (!(op_valid && m_run)) begin
        op_valid = ($urandom % 4) != 0;
        op_data  = OP_W'($urandom);
        ctx_sel  = $urandom % 2;
      end
      if ($urandom % 8 == 0) begin
        hd_we = 1; hd_ctx = $urandom % 2; hd_op = OP_W'($urandom); hd_valid = ($urandom % 4) != 0;
        hd_multi = $urandom % 2; hd_cptr = CA_W'($urandom); hd_uword = 16'($urandom);
      end else if ($urandom % 8 == 0) begin
        int a;
        a = int'($urandom % N_CW);
        hc_we = 1; hc_addr = CA_W'(a); hc_uword = 16'($urandom);
        hc_last = (a == N_CW - 1) || ($urandom % 4 == 0);
        hc_link = hc_last ? CA_W'(0) : CA_W'(a + 1 + int'($urandom % (N_CW - 1 - a)));
      end
      tick();
    end
    op_valid = 0;
    drain(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule